// File: doc/BRIEF.md
# Flash Target Command Sequencer

This block sits on the device side of a byte-wide flash host interface. It takes command, address and data-read cycles from the host and decodes the array read, status read, parameter-page read and reset opcodes. It collects the address bytes and hands each operation to one of several logical units (LUNs). Each LUN owns a page register and a ready bit. An operation in a LUN runs for a nonzero number of clocks that depends on the request. At the end of that time the page register is filled from a small behavioural pattern that stands in for the storage array.

The sequencer checks the transitions of each state in a fixed priority order. It saves a return state so that a status query can interrupt a wait or a transfer. A later read opcode resumes the saved state without sending a second request to the LUN. A separate register drives the shared ready/busy pin from the LUN ready bits. That register runs independently of the command sequencer, so two LUNs can be busy at once.

Top module: `flash_tgt_ctrl`

## Requirements
- R1: `rdy_busy_o` is 1 for ready and 0 for busy. On every clock it takes the AND of all LUN ready bits as they were one cycle earlier.
- R2: An array read is the command 00h, then ADDR_BYTES address cycles, then the command 30h. The first address byte gives the start column (byte mod PAGE_BYTES). In the last address byte, bit 7 selects the LUN and bits 6:0 give the page. The LUN clears its ready bit on the request, and `rdy_busy_o` then stays low for exactly LOAD_BASE + (page mod LOAD_SPREAD) cycles.
- R3: A parameter-page read is the command ECh, then one address byte whose bit 7 selects the LUN. `rdy_busy_o` stays low for exactly PARAM_CYCLES cycles. Byte c of the page then reads as (192 + 5c + lun) mod 256, starting at column 0.
- R4: After an array read completes, each data-read cycle returns the page byte (7·page + 13·col + 64·lun + 1) mod 256. The column starts at the value given in R2 and steps up by one, wrapping modulo PAGE_BYTES.
- R5: The command 70h is accepted in idle, address, confirm, wait, transfer and status-idle states. Until the next read or parameter opcode, data reads return the status byte: 40h if the selected LUN is ready, 00h if it is busy. Status reads do not move the transfer column.
- R6: In a wait state the conditions are checked in this order. LUN completion goes to transfer and drops a 70h that arrives in the same cycle. Otherwise 70h starts a status query. Otherwise a data read with the status flag set moves to a status-idle state.
- R7: The command 00h in status-idle, or in transfer while the status flag is set, clears the flag and resumes the saved state. It issues no new LUN request, so `rdy_busy_o` stays high and the data continues from the saved column.
- R8: The command ECh in status-idle starts a parameter read on another LUN while the first LUN is still busy. `rdy_busy_o` stays low until both have finished.
- R9: Any command other than 00h, 30h, 70h, ECh and FFh is ignored in idle, and so are address and 30h cycles that arrive in idle. None of these changes `rdy_busy_o` or the status flag.
- R10: The command FFh, in any state, returns to idle, aborts LUN work so that `rdy_busy_o` is high one cycle later, clears the status flag and clears the return state. A 70h that follows therefore returns to idle.
- R11: After reset, `rdy_busy_o` is 1 and `io_o` is 00h. A data read in any state other than transfer, with the status flag clear, returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_cmd_i | input | 1 | Command cycle strobe; opcode on `io_i` |
| cyc_addr_i | input | 1 | Address cycle strobe; address byte on `io_i` |
| cyc_rd_i | input | 1 | Data-read cycle strobe; result appears on `io_o` after the edge |
| io_i | input | 8 | Host byte for command and address cycles |
| io_o | output | 8 | Byte returned by the last data-read cycle |
| rdy_busy_o | output | 1 | Shared ready/busy pin, 1 = ready |

## Verification
The assertions assume that at most one of the three cycle strobes is high in any clock. They also assume the host leaves at least one idle clock between cycles, so that no cycle lands in a one-cycle entry or status state. The stimulus sends every cycle through a single task that raises one strobe for one clock and then idles for one clock. The priority case is hit by counting clocks from the confirm edge with the known busy length, which places a 70h exactly on the completion edge and again one cycle before it.

// File: rtl/flt_pkg.sv
package flt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RADDR,
    ST_RCONF,
    ST_RLOAD,
    ST_RWAIT,
    ST_PADDR,
    ST_PLOAD,
    ST_PWAIT,
    ST_XFER,
    ST_STAT,
    ST_SREAD
  } tgt_state_e;

  typedef enum logic {
    LD_ARRAY,
    LD_PARAM
  } load_kind_e;

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_CONFIRM = 8'h30;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_PARAM   = 8'hEC;
  localparam logic [7:0] OP_RESET   = 8'hFF;

  localparam int STAT_RDY_BIT = 6;

endpackage

// File: rtl/flt_lun.sv
module flt_lun
  import flt_pkg::*;
#(
  parameter int PAGE_BYTES   = 8,
  parameter int LUN_ID       = 0,
  parameter int LOAD_BASE    = 20,
  parameter int LOAD_SPREAD  = 8,
  parameter int PARAM_CYCLES = 4,
  parameter int PG_W         = 7,
  localparam int COL_W = $clog2(PAGE_BYTES),
  localparam int MAXC  = (LOAD_BASE + LOAD_SPREAD > PARAM_CYCLES) ?
                         (LOAD_BASE + LOAD_SPREAD) : PARAM_CYCLES,
  localparam int CNT_W = $clog2(MAXC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe_i,
  input  logic             req_i,
  input  load_kind_e       kind_i,
  input  logic [PG_W-1:0]  page_i,
  input  logic [COL_W-1:0] col_i,
  output logic             rdy_o,
  output logic [7:0]       byte_o
);

  logic             rdy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_len;
  load_kind_e       kind_q;
  logic [PG_W-1:0]  page_q;
  logic             finish;
  logic [7:0]       pg_q    [PAGE_BYTES];
  logic [7:0]       pg_fill [PAGE_BYTES];

  // Work length: fixed for the parameter page, page dependent for the array.
  always_comb begin
    if (kind_i == LD_PARAM) begin
      load_len = CNT_W'(PARAM_CYCLES);
    end else begin
      load_len = CNT_W'(LOAD_BASE + (int'(page_i) % LOAD_SPREAD));
    end
  end

  // Behavioural stand-in for the storage array.
  always_comb begin
    for (int b = 0; b < PAGE_BYTES; b++) begin
      if (kind_q == LD_PARAM) begin
        pg_fill[b] = 8'((192 + b * 5 + LUN_ID) % 256);
      end else begin
        pg_fill[b] = 8'((int'(page_q) * 7 + b * 13 + LUN_ID * 64 + 1) % 256);
      end
    end
  end

  assign finish = !rdy_q && (cnt_q == CNT_W'(1)) && !wipe_i && !req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b1;
      cnt_q  <= '0;
      kind_q <= LD_ARRAY;
      page_q <= '0;
    end else if (wipe_i) begin
      rdy_q <= 1'b1;
      cnt_q <= '0;
    end else if (req_i) begin
      rdy_q  <= 1'b0;
      cnt_q  <= load_len;
      kind_q <= kind_i;
      page_q <= page_i;
    end else if (!rdy_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        rdy_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < PAGE_BYTES; b++) begin
        pg_q[b] <= 8'h00;
      end
    end else if (finish) begin
      for (int b = 0; b < PAGE_BYTES; b++) begin
        pg_q[b] <= pg_fill[b];
      end
    end
  end

  assign rdy_o  = rdy_q;
  assign byte_o = pg_q[col_i];

  AST_LUN_BUSY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !wipe_i) |=> !rdy_o); // R2

  AST_LUN_READY_AFTER_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_i |=> rdy_o); // R10

endmodule

// File: rtl/flt_rdy_and.sv
module flt_rdy_and #(
  parameter int LUN_COUNT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LUN_COUNT-1:0] rdy_i,
  output logic                 rb_o
);

  logic [LUN_COUNT:0] chain;
  logic               rb_q;

  assign chain[0] = 1'b1;

  for (genvar g = 0; g < LUN_COUNT; g++) begin : g_and
    assign chain[g+1] = chain[g] & rdy_i[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q <= 1'b1;
    end else begin
      rb_q <= chain[LUN_COUNT];
    end
  end

  assign rb_o = rb_q;

endmodule

// File: rtl/flt_seq.sv
module flt_seq
  import flt_pkg::*;
#(
  parameter int LUN_COUNT  = 2,
  parameter int PAGE_BYTES = 8,
  parameter int ADDR_BYTES = 2,
  localparam int LUN_W  = $clog2(LUN_COUNT),
  localparam int COL_W  = $clog2(PAGE_BYTES),
  localparam int PG_W   = 8 - LUN_W,
  localparam int ACNT_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_v_i,
  input  logic             addr_v_i,
  input  logic             rd_v_i,
  input  logic [7:0]       bus_i,
  input  logic             sel_rdy_i,
  output logic [LUN_W-1:0] sel_o,
  output logic             req_o,
  output load_kind_e       kind_o,
  output logic [PG_W-1:0]  page_o,
  output logic [COL_W-1:0] col_o,
  output logic             stat_o,
  output logic             xfer_o,
  output logic             wipe_o
);

  tgt_state_e        state_q, state_d;
  tgt_state_e        ret_q, ret_d;
  logic              stat_q, stat_d;
  logic [LUN_W-1:0]  sel_q, sel_d;
  logic [PG_W-1:0]   page_q, page_d;
  logic [COL_W-1:0]  cbase_q, cbase_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [ACNT_W-1:0] acnt_q, acnt_d;

  logic is_read, is_conf, is_status, is_param, is_reset, in_wait;

  assign is_read   = cmd_v_i && (bus_i == OP_READ);
  assign is_conf   = cmd_v_i && (bus_i == OP_CONFIRM);
  assign is_status = cmd_v_i && (bus_i == OP_STATUS);
  assign is_param  = cmd_v_i && (bus_i == OP_PARAM);
  assign is_reset  = cmd_v_i && (bus_i == OP_RESET);
  assign in_wait   = (state_q == ST_RWAIT) || (state_q == ST_PWAIT);

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    stat_d  = stat_q;
    sel_d   = sel_q;
    page_d  = page_q;
    cbase_d = cbase_q;
    col_d   = col_q;
    acnt_d  = acnt_q;

    if (is_reset) begin
      state_d = ST_IDLE;
      ret_d   = ST_IDLE;
      stat_d  = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (is_read) begin
            state_d = ST_RADDR;
            acnt_d  = '0;
            stat_d  = 1'b0;
          end else if (is_param) begin
            state_d = ST_PADDR;
            stat_d  = 1'b0;
          end else if (is_status) begin
            state_d = ST_STAT;
            stat_d  = 1'b1;
          end
        end

        ST_RADDR: begin
          if (addr_v_i) begin
            if (acnt_q == '0) begin
              cbase_d = bus_i[COL_W-1:0];
            end
            if (acnt_q == ACNT_W'(ADDR_BYTES - 1)) begin
              sel_d   = bus_i[7 -: LUN_W];
              page_d  = bus_i[PG_W-1:0];
              state_d = ST_RCONF;
            end
            acnt_d = acnt_q + ACNT_W'(1);
          end else if (is_status) begin
            state_d = ST_STAT;
            stat_d  = 1'b1;
          end
        end

        ST_RCONF: begin
          if (is_conf) begin
            state_d = ST_RLOAD;
          end else if (is_read) begin
            state_d = ST_RADDR;
            acnt_d  = '0;
          end else if (is_status) begin
            state_d = ST_STAT;
            stat_d  = 1'b1;
          end
        end

        ST_RLOAD: begin
          state_d = ST_RWAIT;
          ret_d   = ST_RWAIT;
        end

        ST_PADDR: begin
          if (addr_v_i) begin
            sel_d   = bus_i[7 -: LUN_W];
            state_d = ST_PLOAD;
          end else if (is_status) begin
            state_d = ST_STAT;
            stat_d  = 1'b1;
          end
        end

        ST_PLOAD: begin
          state_d = ST_PWAIT;
          ret_d   = ST_PWAIT;
        end

        ST_RWAIT, ST_PWAIT: begin
          // Priority order: completion, then status opcode, then status read.
          if (sel_rdy_i) begin
            state_d = ST_XFER;
            ret_d   = ST_XFER;
            col_d   = (state_q == ST_RWAIT) ? cbase_q : '0;
          end else if (is_status) begin
            state_d = ST_STAT;
            stat_d  = 1'b1;
          end else if (rd_v_i && stat_q) begin
            state_d = ST_SREAD;
          end
        end

        ST_XFER: begin
          if (rd_v_i && !stat_q) begin
            if (col_q == COL_W'(PAGE_BYTES - 1)) begin
              col_d = '0;
            end else begin
              col_d = col_q + COL_W'(1);
            end
          end else if (is_status) begin
            state_d = ST_STAT;
            stat_d  = 1'b1;
          end else if (is_read) begin
            if (stat_q) begin
              stat_d = 1'b0;
            end else begin
              state_d = ST_RADDR;
              acnt_d  = '0;
            end
          end else if (is_param) begin
            state_d = ST_PADDR;
            stat_d  = 1'b0;
          end
        end

        ST_STAT: begin
          state_d = ret_q;
        end

        ST_SREAD: begin
          if (is_read) begin
            state_d = ret_q;
            stat_d  = 1'b0;
          end else if (is_param) begin
            state_d = ST_PADDR;
            stat_d  = 1'b0;
          end else if (is_status) begin
            state_d = ST_STAT;
            stat_d  = 1'b1;
          end
        end

        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_IDLE;
      stat_q  <= 1'b0;
      sel_q   <= '0;
      page_q  <= '0;
      cbase_q <= '0;
      col_q   <= '0;
      acnt_q  <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      stat_q  <= stat_d;
      sel_q   <= sel_d;
      page_q  <= page_d;
      cbase_q <= cbase_d;
      col_q   <= col_d;
      acnt_q  <= acnt_d;
    end
  end

  assign sel_o  = sel_q;
  assign req_o  = (state_q == ST_RLOAD) || (state_q == ST_PLOAD);
  assign kind_o = (state_q == ST_PLOAD) ? LD_PARAM : LD_ARRAY;
  assign page_o = page_q;
  assign col_o  = col_q;
  assign stat_o = stat_q;
  assign xfer_o = (state_q == ST_XFER);
  assign wipe_o = is_reset;

  AST_DONE_BEATS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && sel_rdy_i && !is_reset) |=> (state_q == ST_XFER)); // R6

  AST_STATUS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (is_status && !(in_wait && sel_rdy_i) && (state_q != ST_RLOAD) &&
     (state_q != ST_PLOAD) && (state_q != ST_STAT)) |=> stat_o); // R5

  AST_RESET_CMD_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    is_reset |=> ((state_q == ST_IDLE) && (ret_q == ST_IDLE) && !stat_o)); // R10

  AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && (addr_v_i || is_conf ||
     (cmd_v_i && !is_read && !is_param && !is_status && !is_reset)))
    |=> ((state_q == ST_IDLE) && $stable(stat_o))); // R9

  AST_RESUME_NO_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SREAD) && is_read) |=> !req_o); // R7

endmodule

// File: rtl/flash_tgt_ctrl.sv
module flash_tgt_ctrl
  import flt_pkg::*;
#(
  parameter int LUN_COUNT    = 2,
  parameter int PAGE_BYTES   = 8,
  parameter int ADDR_BYTES   = 2,
  parameter int LOAD_BASE    = 20,
  parameter int LOAD_SPREAD  = 8,
  parameter int PARAM_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_cmd_i,
  input  logic       cyc_addr_i,
  input  logic       cyc_rd_i,
  input  logic [7:0] io_i,
  output logic [7:0] io_o,
  output logic       rdy_busy_o
);

  localparam int LUN_W = $clog2(LUN_COUNT);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = 8 - LUN_W;

  logic [LUN_W-1:0]     sel;
  logic                 req;
  load_kind_e           kind;
  logic [PG_W-1:0]      page;
  logic [COL_W-1:0]     col;
  logic                 stat;
  logic                 xfer;
  logic                 wipe;
  logic [LUN_COUNT-1:0] lun_rdy;
  logic [7:0]           lun_byte [LUN_COUNT];
  logic                 sel_rdy;
  logic [7:0]           status_byte;
  logic [7:0]           io_q;

  assign sel_rdy = lun_rdy[sel];

  flt_seq #(
    .LUN_COUNT  (LUN_COUNT),
    .PAGE_BYTES (PAGE_BYTES),
    .ADDR_BYTES (ADDR_BYTES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_v_i   (cyc_cmd_i),
    .addr_v_i  (cyc_addr_i),
    .rd_v_i    (cyc_rd_i),
    .bus_i     (io_i),
    .sel_rdy_i (sel_rdy),
    .sel_o     (sel),
    .req_o     (req),
    .kind_o    (kind),
    .page_o    (page),
    .col_o     (col),
    .stat_o    (stat),
    .xfer_o    (xfer),
    .wipe_o    (wipe)
  );

  for (genvar g = 0; g < LUN_COUNT; g++) begin : g_lun
    flt_lun #(
      .PAGE_BYTES   (PAGE_BYTES),
      .LUN_ID       (g),
      .LOAD_BASE    (LOAD_BASE),
      .LOAD_SPREAD  (LOAD_SPREAD),
      .PARAM_CYCLES (PARAM_CYCLES),
      .PG_W         (PG_W)
    ) u_lun (
      .clk    (clk),
      .rst_n  (rst_n),
      .wipe_i (wipe),
      .req_i  (req && (sel == LUN_W'(g))),
      .kind_i (kind),
      .page_i (page),
      .col_i  (col),
      .rdy_o  (lun_rdy[g]),
      .byte_o (lun_byte[g])
    );
  end

  flt_rdy_and #(
    .LUN_COUNT (LUN_COUNT)
  ) u_rb (
    .clk   (clk),
    .rst_n (rst_n),
    .rdy_i (lun_rdy),
    .rb_o  (rdy_busy_o)
  );

  always_comb begin
    status_byte               = 8'h00;
    status_byte[STAT_RDY_BIT] = sel_rdy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q <= 8'h00;
    end else if (cyc_rd_i) begin
      if (stat) begin
        io_q <= status_byte;
      end else if (xfer) begin
        io_q <= lun_byte[sel];
      end else begin
        io_q <= 8'h00;
      end
    end
  end

  assign io_o = io_q;

  AST_RB_LOW_WHEN_ANY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(&lun_rdy) |=> !rdy_busy_o); // R1

  AST_RB_HIGH_WHEN_ALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (&lun_rdy) |=> rdy_busy_o); // R1

endmodule

// File: tb/flash_tgt_ctrl_bench.sv
module flash_tgt_ctrl_bench;

  localparam int PB    = 8;
  localparam int LBASE = 20;
  localparam int LSPR  = 8;
  localparam int PCYC  = 4;

  logic       clk;
  logic       rst_n;
  logic       cmd, adr, rd;
  logic [7:0] bus;
  logic [7:0] dout;
  logic       rb;

  int tests;
  int fails;
  bit done;

  flash_tgt_ctrl u_flash_tgt_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_cmd_i  (cmd),
    .cyc_addr_i (adr),
    .cyc_rd_i   (rd),
    .io_i       (bus),
    .io_o       (dout),
    .rdy_busy_o (rb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] arr_b(int lun, int page, int col);
    return 8'((page * 7 + col * 13 + lun * 64 + 1) % 256);
  endfunction

  function automatic logic [7:0] par_b(int lun, int col);
    return 8'((192 + col * 5 + lun) % 256);
  endfunction

  function automatic int busy_n(int page);
    return LBASE + (page % LSPR);
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // One host cycle: strobe for one clock, then one idle clock.
  task automatic put(int kind, logic [7:0] b);
    cmd = (kind == 0);
    adr = (kind == 1);
    rd  = (kind == 2);
    bus = b;
    @(posedge clk);
    @(negedge clk);
    cmd = 1'b0;
    adr = 1'b0;
    rd  = 1'b0;
    bus = 8'h00;
    @(negedge clk);
  endtask

  task automatic rd_byte(output logic [7:0] v);
    put(2, 8'h00);
    v = dout;
  endtask

  task automatic start_read(int lun, int page, int colb);
    put(0, 8'h00);
    put(1, 8'(colb));
    put(1, 8'(lun * 128 + page));
    put(0, 8'h30);
  endtask

  task automatic count_busy(output int lows);
    lows = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (rb) break;
      lows++;
    end
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 300; k++) begin
      if (rb) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int lows;
    int n;
    tests = 0;
    fails = 0;
    done  = 1'b0;
    cmd = 1'b0; adr = 1'b0; rd = 1'b0; bus = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 rb after reset", int'(rb), 1);
    chk("R11 io after reset", int'(dout), 8'h00);
    rd_byte(v);
    chk("R11 idle read", int'(v), 8'h00);

    // R5 status from idle
    put(0, 8'h70);
    rd_byte(v);
    chk("R5 idle status", int'(v), 8'h40);

    // R9 unknown opcode and stray cycles in idle
    put(0, 8'h55);
    put(1, 8'h11);
    put(1, 8'h22);
    put(0, 8'h30);
    repeat (3) begin
      @(negedge clk);
      chk("R9 rb stays ready", int'(rb), 1);
    end
    rd_byte(v);
    chk("R9 status flag kept", int'(v), 8'h40);

    // R2 / R4 sweep over LUNs, pages and start columns
    for (int lun = 0; lun < 2; lun++) begin
      for (int page = 0; page < 9; page++) begin
        for (int cs = 0; cs < 2; cs++) begin
          int colb;
          colb = (cs == 0) ? 0 : (3 + page);
          start_read(lun, page, colb);
          count_busy(lows);
          chk("R2 busy length", lows, busy_n(page));
          for (int k = 0; k < PB + 2; k++) begin
            rd_byte(v);
            chk("R4 page byte", int'(v), int'(arr_b(lun, page, (colb + k) % PB)));
          end
        end
      end
    end

    // R3 parameter page on each LUN
    for (int lun = 0; lun < 2; lun++) begin
      put(0, 8'hEC);
      put(1, 8'(lun * 128));
      count_busy(lows);
      chk("R3 param busy length", lows, PCYC);
      for (int k = 0; k < PB; k++) begin
        rd_byte(v);
        chk("R3 param byte", int'(v), int'(par_b(lun, k)));
      end
    end

    // R5 / R6 / R7 status during busy, status-idle, resume
    start_read(0, 3, 2);
    put(0, 8'h70);
    rd_byte(v);
    chk("R5 busy status", int'(v), 8'h00);
    wait_ready();
    repeat (3) @(negedge clk);
    rd_byte(v);
    chk("R6 status-idle read", int'(v), 8'h40);
    put(0, 8'h00);
    for (int k = 0; k < 5; k++) begin
      chk("R7 no re-issue", int'(rb), 1);
      @(negedge clk);
    end
    rd_byte(v);
    chk("R7 resumed data", int'(v), int'(arr_b(0, 3, 2)));
    rd_byte(v);
    chk("R7 resumed next", int'(v), int'(arr_b(0, 3, 3)));
    put(0, 8'h70);
    rd_byte(v);
    chk("R5 status in transfer", int'(v), 8'h40);
    put(0, 8'h00);
    rd_byte(v);
    chk("R7 column kept", int'(v), int'(arr_b(0, 3, 4)));

    // R6 completion beats a same-cycle status opcode
    n = busy_n(5);
    start_read(1, 5, 0);
    repeat (n) @(negedge clk);
    put(0, 8'h70);
    rd_byte(v);
    chk("R6 done wins", int'(v), int'(arr_b(1, 5, 0)));

    // R6 status one cycle before completion is taken
    start_read(1, 5, 0);
    repeat (n - 1) @(negedge clk);
    put(0, 8'h70);
    rd_byte(v);
    chk("R6 status taken", int'(v), 8'h40);
    put(0, 8'h00);
    rd_byte(v);
    chk("R7 resume after late status", int'(v), int'(arr_b(1, 5, 0)));

    // R8 interleaved parameter read on the other LUN
    start_read(0, 7, 0);
    put(0, 8'h70);
    rd_byte(v);
    chk("R8 first busy", int'(v), 8'h00);
    put(0, 8'hEC);
    put(1, 8'h80);
    repeat (PCYC + 2) @(negedge clk);
    chk("R8 rb low while one busy", int'(rb), 0);
    put(0, 8'h70);
    rd_byte(v);
    chk("R8 second ready", int'(v), 8'h40);
    chk("R1 rb is AND", int'(rb), 0);
    wait_ready();
    chk("R1 rb high when all ready", int'(rb), 1);
    put(0, 8'h00);
    rd_byte(v);
    chk("R8 param data", int'(v), int'(par_b(1, 0)));

    // R10 reset opcode during a busy read
    put(0, 8'h00);
    put(1, 8'h00);
    put(1, 8'h01);
    put(0, 8'h30);
    repeat (3) @(negedge clk);
    chk("R10 busy before reset", int'(rb), 0);
    put(0, 8'hFF);
    chk("R10 rb ready", int'(rb), 1);
    rd_byte(v);
    chk("R10 flag cleared", int'(v), 8'h00);
    put(0, 8'h70);
    rd_byte(v);
    chk("R10 lun ready status", int'(v), 8'h40);
    put(0, 8'h00);
    rd_byte(v);
    chk("R10 return state cleared", int'(v), 8'h00);
    put(1, 8'h00);
    put(1, 8'h02);
    put(0, 8'h30);
    count_busy(lows);
    chk("R2 busy after reset", lows, busy_n(2));
    rd_byte(v);
    chk("R4 data after reset", int'(v), int'(arr_b(0, 2, 0)));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule